// File: doc/BRIEF.md
# Transaction ID Allocator with Outstanding Tracking

This block hands out transaction IDs to requests that arrive from a bus-controller front end before they go out on an AXI-style master port, and keeps count of how many of those requests are still in flight. Each request is marked as posted or non-posted. Posted traffic, which includes bulk memory writes, always travels on a single ordering ID (ID 0), so all of it completes in the order it was issued. Non-posted traffic, which includes bulk memory reads, takes one of the remaining IDs (1 to 15) from a free pool. The lowest free ID is always chosen.

Reads and writes share one budget of outstanding transactions. While that budget is used up, the block holds `req_ready` low. It also holds `req_ready` low for a non-posted request when no ID is free. A returning completion decrements the count. A completion that carries a non-zero ID also returns that ID to the pool, and the ID can be handed out again from the following cycle. An accepted request is reported one cycle later on a registered grant output that carries the assigned ID.

Top module: `axi_tag_allocator`

## Requirements
- R1: Synchronous active-high reset leaves no transaction outstanding. IDs 1 to 15 are free, `grant_valid` is 0 and `req_ready` is 1. The first non-posted request after reset receives ID 1.
- R2: A request accepted with `req_posted`=1 is granted ID 0.
- R3: A request accepted with `req_posted`=0 is granted the lowest-numbered free ID in the range 1 to 15.
- R4: When IDs 1 to 15 are all in use, `req_ready` is 0 for a non-posted request. A posted request is still accepted while fewer than 16 transactions are outstanding.
- R5: When 16 transactions are outstanding, `req_ready` is 0 for both kinds of request.
- R6: A completion with a non-zero `cpl_id` returns that ID to the pool. The ID can be granted from the next cycle onwards.
- R7: A completion with `cpl_id`=0 lowers the outstanding count by one and frees no ID.
- R8: When a request is accepted in the same cycle that a completion arrives, the outstanding count is unchanged.
- R9: `grant_valid` is 1 for exactly the one cycle after each acceptance (`req_valid` and `req_ready` both 1 at a clock edge), with `grant_id` holding the assigned ID. At all other times `grant_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is offered |
| req_posted | input | 1 | 1 = posted request, 0 = non-posted request |
| req_ready | output | 1 | The offered request can be accepted this cycle |
| cpl_valid | input | 1 | A completion returns this cycle |
| cpl_id | input | 4 | ID of the returning completion |
| grant_valid | output | 1 | A request was accepted at the previous edge |
| grant_id | output | 4 | ID assigned to that request |

## Verification
The assertions assume that completions arrive only for transactions that are actually outstanding. A completion on ID 0 is therefore assumed only while a posted request is in flight, and a completion on a non-zero ID only while that ID is held. Without this assumption the shadow count in the checker could wrap. The stimulus tracks which IDs it has received and how many posted requests are open. It returns completions only for those, and never more than one per cycle.

// File: rtl/tag_alloc_pkg.sv
package tag_alloc_pkg;

  localparam int unsigned ID_W_DEF    = 4;
  localparam int unsigned MAX_OUT_DEF = 16;
  localparam int unsigned ORDER_ID    = 0;

  typedef enum logic {
    KIND_NONPOSTED = 1'b0,
    KIND_POSTED    = 1'b1
  } req_kind_e;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/tag_free_pool.sv
module tag_free_pool #(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned FIXED_ID = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_en,
  input  logic            give_en,
  input  logic [ID_W-1:0] give_id,
  output logic            any_free,
  output logic [ID_W-1:0] low_id
);

  localparam int unsigned NUM_IDS = 1 << ID_W;

  logic [NUM_IDS-1:0] free_vec;

  // one flop per pool slot; the ordering ID never enters the pool
  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    if (g == FIXED_ID) begin : g_fixed
      assign free_vec[g] = 1'b0;
    end else begin : g_pool
      logic slot_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          slot_q <= 1'b1;
        end else if (take_en && (low_id == ID_W'(g))) begin
          slot_q <= 1'b0;
        end else if (give_en && (give_id == ID_W'(g))) begin
          slot_q <= 1'b1;
        end
      end
      assign free_vec[g] = slot_q;
    end
  end

  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    low_id = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        low_id = ID_W'(i);
      end
    end
  end

  assign any_free = |free_vec;

endmodule

// File: rtl/tag_outst_ctr.sv
module tag_outst_ctr
  import tag_alloc_pkg::*;
#(
  parameter int unsigned MAX_OUT = 16,
  parameter int unsigned CNT_W   = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic full
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  cnt_op_e          op;

  always_comb begin
    unique case ({inc, dec})
      2'b10:   op = CNT_UP;
      2'b01:   op = CNT_DOWN;
      default: op = CNT_HOLD;
    endcase
  end

  always_comb begin
    unique case (op)
      CNT_UP:   cnt_d = cnt_q + CNT_W'(1);
      CNT_DOWN: cnt_d = cnt_q - CNT_W'(1);
      default:  cnt_d = cnt_q;
    endcase
  end

  // full flag is registered from the next count so ready has no adder in its path
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      full  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      full  <= (cnt_d == CNT_W'(MAX_OUT));
    end
  end

endmodule

// File: rtl/tag_grant_reg.sv
module tag_grant_reg #(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc,
  input  logic [ID_W-1:0] sel_id,
  output logic            grant_valid,
  output logic [ID_W-1:0] grant_id
);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_id    <= '0;
    end else begin
      grant_valid <= acc;
      if (acc) begin
        grant_id <= sel_id;
      end
    end
  end

endmodule

// File: rtl/axi_tag_allocator.sv
module axi_tag_allocator
  import tag_alloc_pkg::*;
#(
  parameter int unsigned ID_W    = ID_W_DEF,
  parameter int unsigned MAX_OUT = MAX_OUT_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_posted,
  output logic            req_ready,
  input  logic            cpl_valid,
  input  logic [ID_W-1:0] cpl_id,
  output logic            grant_valid,
  output logic [ID_W-1:0] grant_id
);

  localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [ID_W-1:0] ORD_ID = ID_W'(ORDER_ID);

  req_kind_e       kind;
  logic            full;
  logic            any_free;
  logic [ID_W-1:0] low_id;
  logic            accept;
  logic            take_en;
  logic            give_en;
  logic [ID_W-1:0] sel_id;

  assign kind      = req_kind_e'(req_posted);
  assign req_ready = !full && ((kind == KIND_POSTED) || any_free);
  assign accept    = req_valid && req_ready;
  assign take_en   = accept && (kind == KIND_NONPOSTED);
  assign give_en   = cpl_valid && (cpl_id != ORD_ID);
  assign sel_id    = (kind == KIND_POSTED) ? ORD_ID : low_id;

  tag_free_pool #(
    .ID_W     (ID_W),
    .FIXED_ID (ORDER_ID)
  ) u_pool (
    .clk      (clk),
    .rst      (rst),
    .take_en  (take_en),
    .give_en  (give_en),
    .give_id  (cpl_id),
    .any_free (any_free),
    .low_id   (low_id)
  );

  tag_outst_ctr #(
    .MAX_OUT (MAX_OUT),
    .CNT_W   (CNT_W)
  ) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .inc  (accept),
    .dec  (cpl_valid),
    .full (full)
  );

  tag_grant_reg #(
    .ID_W (ID_W)
  ) u_grant (
    .clk         (clk),
    .rst         (rst),
    .acc         (accept),
    .sel_id      (sel_id),
    .grant_valid (grant_valid),
    .grant_id    (grant_id)
  );

endmodule

// File: rtl/tag_alloc_chk.sv
module tag_alloc_chk #(
  parameter int unsigned ID_W    = 4,
  parameter int unsigned MAX_OUT = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_posted,
  input logic            req_ready,
  input logic            cpl_valid,
  input logic [ID_W-1:0] cpl_id,
  input logic            grant_valid,
  input logic [ID_W-1:0] grant_id
);

  localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);

  logic             acc;
  logic [CNT_W-1:0] shadow;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (acc && !cpl_valid) begin
      shadow <= shadow + CNT_W'(1);
    end else if (!acc && cpl_valid) begin
      shadow <= shadow - CNT_W'(1);
    end
  end

  // R9
  grant_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> grant_valid);

  // R9
  no_spurious_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !grant_valid);

  // R2
  posted_on_order_id_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_posted) |=> (grant_id == '0));

  // R3
  nonposted_off_order_id_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_posted) |=> (grant_id != '0));

  // R5
  budget_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (shadow == CNT_W'(MAX_OUT)) |-> !req_ready);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    shadow <= CNT_W'(MAX_OUT));

endmodule

bind axi_tag_allocator tag_alloc_chk #(
  .ID_W    (ID_W),
  .MAX_OUT (MAX_OUT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_posted  (req_posted),
  .req_ready   (req_ready),
  .cpl_valid   (cpl_valid),
  .cpl_id      (cpl_id),
  .grant_valid (grant_valid),
  .grant_id    (grant_id)
);

// File: tb/sim_axi_tag_allocator.sv
`timescale 1ns/1ps
module sim_axi_tag_allocator;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_posted = 1'b0;
  logic       req_ready;
  logic       cpl_valid = 1'b0;
  logic [3:0] cpl_id = 4'd0;
  logic       grant_valid;
  logic [3:0] grant_id;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  axi_tag_allocator u0 (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_posted  (req_posted),
    .req_ready   (req_ready),
    .cpl_valid   (cpl_valid),
    .cpl_id      (cpl_id),
    .grant_valid (grant_valid),
    .grant_id    (grant_id)
  );

  // fields: valid, posted, cpl_valid, cpl_id[3:0], exp_ready, exp_grant, exp_id[3:0]
  localparam logic [12:0] VEC [8] = '{
    13'b1_0_0_0000_1_1_0001,  // R1 R3 first non-posted -> 1
    13'b1_0_0_0000_1_1_0010,  // R3 -> 2
    13'b1_1_0_0000_1_1_0000,  // R2 posted -> 0
    13'b1_0_1_0001_1_1_0011,  // R6 ID 1 returns, not reusable yet -> 3
    13'b1_0_0_0000_1_1_0001,  // R6 ID 1 reused
    13'b1_1_1_0000_1_1_0000,  // R2 R8 posted with posted completion
    13'b0_0_0_0000_1_0_0000,  // R9 idle, no grant
    13'b1_0_0_0000_1_1_0100   // R3 -> 4
  };

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic check_id(input logic [3:0] act, input logic [3:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // called just after a negedge; drives for one cycle and checks ready then the grant
  task automatic step(input logic v, input logic p, input logic cv, input logic [3:0] cid,
                      input logic er, input logic eg, input logic [3:0] gid, input string tag);
    req_valid  = v;
    req_posted = p;
    cpl_valid  = cv;
    cpl_id     = cid;
    #1;
    check(req_ready, er, {tag, " ready"});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cpl_valid = 1'b0;
    check(grant_valid, eg, {tag, " grant_valid"});
    if (eg) check_id(grant_id, gid, {tag, " grant_id"});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    cpl_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    #1;
    check(grant_valid, 1'b0, "R1 grant_valid after reset");
    check(req_ready, 1'b1, "R1 ready after reset");
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      logic [12:0] e;
      e = VEC[k];
      step(e[12], e[11], e[10], e[9:6], e[5], e[4], e[3:0], $sformatf("R3 vector %0d", k));
    end

    do_reset();
    // R3 fill every pool ID in ascending order
    for (int k = 1; k < 16; k++) begin
      step(1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'(k), $sformatf("R3 fill %0d", k));
    end
    // R4 pool empty: non-posted stalls, posted still accepted (count 15 -> 16)
    step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, "R4 non-posted with empty pool");
    step(1'b1, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd0, "R4 posted with empty pool");
    // R5 budget used up: posted stalls too
    step(1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, "R5 posted at full budget");
    step(1'b1, 1'b1, 1'b1, 4'd5, 1'b0, 1'b0, 4'd0, "R5 full while ID 5 returns");
    // R6 ID 5 granted again
    step(1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd5, "R6 reuse of returned ID 5");
    // R7 posted completion: count drops, pool stays empty
    step(1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 4'd0, "R5 full before posted completion");
    step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, "R7 no ID freed by posted completion");
    step(1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0, "R7 posted ready after count drop");
    // R8 accept and completion together keep count at 15
    step(1'b1, 1'b1, 1'b1, 4'd3, 1'b1, 1'b1, 4'd0, "R8 posted accept with completion");
    step(1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd0, "R8 count unchanged, posted ready");
    step(1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 4'd3, "R6 ID 3 granted after return");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule